// File: doc/BRIEF.md
# Rate-Half Convolutional Encoder

This block turns a stream of message bits into a stream of coded bit pairs. It uses a constraint length of three, so it keeps the two most recent message bits as its state. Each message bit enters through a valid/ready handshake. Each message bit then produces one registered output pair, and the pair leaves through its own valid/ready handshake. Two modulo-2 sums form the pair. One sum has taps 111 (1+D+D^2) and the other has taps 101 (1+D^2).

Start and end markers travel with the message bits and frame them. The bit that carries the start marker is coded against an all-zero state, whatever earlier frames left behind. After the bit that carries the end marker, the block stops taking input. It then feeds two zero tail bits through the same sums, which returns the state to zero. The second tail pair carries an end-of-frame flag. With its output ready held high, the block gives one pair per clock.

Top module: `conv_enc_r2`

## Requirements
- R1: While reset is high and in the cycle after it falls, out_valid and out_eof are 0 and in_ready is 1.
- R2: For a message bit b with state bits d1 (previous bit) and d2 (the bit before it), out_pair[1] = b^d1^d2 and out_pair[0] = b^d2. out_pair[1] is the bit sent first.
- R3: An accepted bit that has in_sof set is coded with d1 = d2 = 0, whatever bits came before it.
- R4: After an accepted bit that has in_eof set, the block emits exactly two further pairs, coded from zero input bits. in_ready stays 0 until the second of these pairs has been loaded into the output register.
- R5: out_eof is 1 only on the second tail pair of a frame and is 0 on every data pair.
- R6: While out_valid is 1 and out_ready is 0, out_pair, out_eof and out_valid hold their values and in_ready is 0.
- R7: The message 1,0,1,0,1 (first bit first), framed as one frame, yields the pairs 11,10,00,10,00,10,11. The last of these carries out_eof.
- R8: With out_ready held at 1, a message bit is accepted every cycle and the output shows one pair per cycle, with no gaps, until the frame's last tail pair.
- R9: A synchronous reset in the middle of a frame clears the state and cancels any tail pairs still pending. The next bit is then coded against a zero state even without in_sof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message bit offered |
| in_ready | output | 1 | Block can take a message bit this cycle |
| in_bit | input | 1 | Message bit |
| in_sof | input | 1 | Bit is the first of its frame |
| in_eof | input | 1 | Bit is the last of its frame |
| out_valid | output | 1 | Coded pair present |
| out_ready | input | 1 | Sink takes the pair this cycle |
| out_pair | output | 2 | Coded pair; bit 1 from taps 111, bit 0 from taps 101 |
| out_eof | output | 1 | Pair is the frame's final tail pair |

## Verification
A wrong state bit shows up quickly at out_pair. An error in the newest bit flips out_pair[1] on the very next pair. An error in the older bit flips both output bits on the next pair. A wrong tail count or a stuck clear shows at the end of the frame. The frame then has the wrong number of pairs, or out_eof lands on the wrong pair. in_ready may also reopen early or stay closed, which stalls the next frame within a few cycles. The bench codes every message of one to eight bits under random stalls on both sides, so each of these faults reaches a port.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;

  // Default code: constraint length 3, path 0 taps 111, path 1 taps 101
  localparam int unsigned CE_K_DEF    = 3;
  localparam int unsigned CE_NOUT_DEF = 2;
  localparam logic [CE_K_DEF*CE_NOUT_DEF-1:0] CE_GENS_DEF = 6'b101_111;

  // Source of the bit being coded in a cycle
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_DATA = 2'd1,
    SRC_TAIL = 2'd2
  } ce_src_e;

endpackage

// File: rtl/conv_enc_ctrl.sv
module conv_enc_ctrl #(
  parameter int unsigned MEM = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_sof,
  input  logic in_eof,
  input  logic slot_free,
  output logic in_ready,
  output logic accept,
  output logic tail_go,
  output logic tail_last,
  output logic clear_state
);

  localparam int unsigned TW = $clog2(MEM + 1);

  logic [TW-1:0] tail_cnt;
  logic          tail_pend;

  assign tail_pend   = (tail_cnt != '0);
  assign in_ready    = slot_free && !tail_pend;
  assign accept      = in_valid && in_ready;
  assign tail_go     = slot_free && tail_pend;
  assign tail_last   = tail_go && (tail_cnt == TW'(1));
  assign clear_state = accept && in_sof;

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_cnt <= '0;
    end else if (accept && in_eof) begin
      tail_cnt <= TW'(MEM);
    end else if (tail_go) begin
      tail_cnt <= tail_cnt - TW'(1);
    end
  end

endmodule

// File: rtl/conv_enc_shreg.sv
module conv_enc_shreg #(
  parameter int unsigned K = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  input  logic         clear,
  input  logic         bit_in,
  output logic [K-1:0] taps
);

  localparam int unsigned MEM = K - 1;

  // hist[0] is the newest stored bit (D), hist[MEM-1] the oldest
  logic [MEM-1:0] hist;
  logic [MEM-1:0] hist_eff;

  assign hist_eff = clear ? '0 : hist;
  assign taps     = {hist_eff, bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (advance) begin
      hist <= taps[MEM-1:0];
    end
  end

endmodule

// File: rtl/conv_enc_parity.sv
module conv_enc_parity #(
  parameter int unsigned              K    = 3,
  parameter int unsigned              NOUT = 2,
  parameter logic [K*NOUT-1:0]        GENS = 6'b101_111
) (
  input  logic [K-1:0]    taps,
  output logic [NOUT-1:0] coded
);

  // Path p lands on bit NOUT-1-p, so path 0 is the first bit sent
  for (genvar p = 0; p < NOUT; p++) begin : g_path
    assign coded[NOUT-1-p] = ^(taps & GENS[p*K +: K]);
  end

endmodule

// File: rtl/conv_enc_outreg.sv
module conv_enc_outreg #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] q,
  output logic         slot_free
);

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      q         <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/conv_enc_r2.sv
module conv_enc_r2
  import conv_enc_pkg::*;
#(
  parameter int unsigned             K    = CE_K_DEF,
  parameter int unsigned             NOUT = CE_NOUT_DEF,
  parameter logic [K*NOUT-1:0]       GENS = CE_GENS_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_bit,
  input  logic            in_sof,
  input  logic            in_eof,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [NOUT-1:0] out_pair,
  output logic            out_eof
);

  localparam int unsigned MEM = K - 1;
  localparam int unsigned OW  = NOUT + 1;

  logic            slot_free;
  logic            accept;
  logic            tail_go;
  logic            tail_last;
  logic            clear_state;
  logic            enc_bit;
  logic            advance;
  ce_src_e         src;
  logic [K-1:0]    taps;
  logic [NOUT-1:0] coded;
  logic [OW-1:0]   oq;

  conv_enc_ctrl #(.MEM(MEM)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .slot_free  (slot_free),
    .in_ready   (in_ready),
    .accept     (accept),
    .tail_go    (tail_go),
    .tail_last  (tail_last),
    .clear_state(clear_state)
  );

  always_comb begin
    if (tail_go)     src = SRC_TAIL;
    else if (accept) src = SRC_DATA;
    else             src = SRC_IDLE;
  end

  assign enc_bit = (src == SRC_DATA) ? in_bit : 1'b0;
  assign advance = (src != SRC_IDLE);

  conv_enc_shreg #(.K(K)) u_shreg (
    .clk    (clk),
    .rst    (rst),
    .advance(advance),
    .clear  (clear_state),
    .bit_in (enc_bit),
    .taps   (taps)
  );

  conv_enc_parity #(.K(K), .NOUT(NOUT), .GENS(GENS)) u_parity (
    .taps (taps),
    .coded(coded)
  );

  conv_enc_outreg #(.W(OW)) u_outreg (
    .clk      (clk),
    .rst      (rst),
    .load     (advance),
    .d        ({tail_last, coded}),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .q        (oq),
    .slot_free(slot_free)
  );

  assign out_pair = oq[NOUT-1:0];
  assign out_eof  = oq[NOUT] && out_valid;

endmodule

// File: rtl/conv_enc_r2_chk.sv
module conv_enc_r2_chk #(
  parameter int unsigned NOUT = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_bit,
  input logic            in_sof,
  input logic            in_eof,
  input logic            out_valid,
  input logic            out_ready,
  input logic [NOUT-1:0] out_pair,
  input logic            out_eof
);

  assert_eof_valid_R5: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> out_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pair) && $stable(out_eof)));

  assert_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_tail_block_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_eof) |=> !in_ready);

  assert_last_data_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_eof) |=> (out_valid && !out_eof));

  assert_sof_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_sof && !in_bit) |=> (out_pair == '0));

endmodule

bind conv_enc_r2 conv_enc_r2_chk #(.NOUT(NOUT)) u_chk (.*);

// File: tb/tb_conv_enc_r2.sv
module tb_conv_enc_r2;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_bit, in_sof, in_eof, in_ready;
  logic       out_valid, out_ready, out_eof;
  logic [1:0] out_pair;

  int errors = 0;
  int checks = 0;
  logic [2:0] expq[$];
  logic [2:0] cap[$];
  logic       bd1 = 1'b0, bd2 = 1'b0;
  logic       held_v = 1'b0;
  logic [2:0] held = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic       bp_on = 1'b0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  conv_enc_r2 dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pair(out_pair), .out_eof(out_eof)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model of R2..R5: expected {eof, pair} for each accepted bit
  task automatic push_bit(input logic b, input logic s, input logic e);
    if (s) begin bd1 = 1'b0; bd2 = 1'b0; end
    expq.push_back({1'b0, b ^ bd1 ^ bd2, b ^ bd2});
    bd2 = bd1; bd1 = b;
    if (e) begin
      expq.push_back({1'b0, bd1 ^ bd2, bd2});
      bd2 = bd1; bd1 = 1'b0;
      expq.push_back({1'b1, bd1 ^ bd2, bd2});
      bd2 = bd1; bd1 = 1'b0;
    end
  endtask

  task automatic cycle(input logic v, input logic b, input logic s, input logic e,
                       output logic took);
    logic [2:0] x;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_on ? (lfsr[0] | lfsr[3]) : 1'b1;
    in_valid = v; in_bit = b; in_sof = s; in_eof = e;
    #1;
    if (held_v)
      chk(out_valid && ({out_eof, out_pair} == held), "R6 held pair",
          {out_valid, out_eof, out_pair}, {1'b1, held});
    if (out_valid && !out_ready)
      chk(!in_ready, "R6 no accept while stalled", in_ready, 0);
    if (in_ready)
      chk(expq.size() == 0 || (expq.size() == 1 && out_valid && out_ready),
          "R4 in_ready low while tail pending", expq.size(), 0);
    took = v && in_ready;
    if (out_valid && out_ready) begin
      cap.push_back({out_eof, out_pair});
      if (expq.size() == 0) begin
        chk(1'b0, "R4 extra pair", {out_eof, out_pair}, 0);
      end else begin
        x = expq.pop_front();
        chk({out_eof, out_pair} == x, "R2 R5 coded pair", {out_eof, out_pair}, x);
      end
    end
    held_v = out_valid && !out_ready;
    held   = {out_eof, out_pair};
    if (took) push_bit(b, s, e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_bit = 1'b0;
    out_ready = 1'b1;
    expq.delete(); cap.delete();
    bd1 = 1'b0; bd2 = 1'b0; held_v = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(!out_valid && !out_eof && in_ready, "R1 R9 state during reset",
        {out_valid, out_eof, in_ready}, 3'b001);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(!out_valid && !out_eof && in_ready, "R1 R9 state after reset",
        {out_valid, out_eof, in_ready}, 3'b001);
  endtask

  task automatic drain();
    logic t;
    for (int n = 0; n < 40 && expq.size() != 0; n++) cycle(1'b0, 1'b0, 1'b0, 1'b0, t);
    chk(expq.size() == 0, "R4 all pairs delivered", expq.size(), 0);
  endtask

  initial begin
    logic t;
    logic [2:0] r7 [7];
    rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    out_ready = 1'b1;
    do_reset();

    // R7 and R8: worked example, no stalls
    bp_on = 1'b0; cap.delete();
    r7 = '{3'b011, 3'b010, 3'b000, 3'b010, 3'b000, 3'b010, 3'b111};
    for (int i = 0; i < 5; i++) begin
      cycle(1'b1, (i % 2) == 0, i == 0, i == 4, t);
      chk(t, "R8 bit accepted every cycle", t, 1);
    end
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0, t);
    chk(cap.size() == 7, "R8 pairs without gaps", cap.size(), 7);
    for (int i = 0; i < 7 && i < cap.size(); i++)
      chk(cap[i] == r7[i], "R7 example pair", cap[i], r7[i]);
    drain();

    // R3: new frame starts mid-stream on a dirty state
    cap.delete();
    cycle(1'b1, 1'b1, 1'b1, 1'b0, t);
    cycle(1'b1, 1'b1, 1'b0, 1'b0, t);
    cycle(1'b1, 1'b0, 1'b1, 1'b1, t);
    drain();
    chk(cap.size() == 5 && cap[2] == 3'b000, "R3 state cleared at start", cap[2], 0);

    // R9: reset while tail pending, then a frame without a start marker
    cycle(1'b1, 1'b1, 1'b1, 1'b0, t);
    cycle(1'b1, 1'b1, 1'b0, 1'b1, t);
    do_reset();
    cycle(1'b1, 1'b1, 1'b0, 1'b1, t);
    drain();
    chk(cap.size() == 3 && cap[0] == 3'b011 && cap[1] == 3'b010 && cap[2] == 3'b111,
        "R9 coding after reset", cap.size(), 3);

    // Sweep: every message of length 1..8 with random gaps and stalls
    bp_on = 1'b1;
    for (int len = 1; len <= 8; len++) begin
      for (int m = 0; m < (1 << len); m++) begin
        int i;
        i = 0;
        while (i < len) begin
          if (lfsr[9] & lfsr[2]) begin
            cycle(1'b0, 1'b0, 1'b0, 1'b0, t);
          end else begin
            cycle(1'b1, m[i], i == 0, i == len - 1, t);
            if (t) i++;
          end
        end
      end
    end
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired R4 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule